// File: doc/BRIEF.md
# Three-Phase Protected Gate Control

This block sits between a motor controller's PWM outputs and the gate drivers of three half bridges. Each phase has a top command and a bottom command. The block turns them into a top-gate enable, a bottom-gate enable and a high-impedance flag for that phase. A phase is driven only when exactly one of its two commands is high. When both commands are high, or both are low, the phase floats.

Every input passes through a two-flop synchronizer. Five global sources can force all three phases off at once: two disable inputs, an undervoltage flag for each of the two supply domains, and a current-limit trip. When one device of a phase switches off, the opposite device of that phase must wait a programmable dead time, counted in clock cycles, before it may switch on. This keeps the two devices from conducting together during a commutation.

Top module: `tri_phase_gate_ctrl`

## Requirements
- R1: When a phase's top command is 1 and its bottom command is 0, and nothing is disabling the outputs, that phase's top gate is 1, its bottom gate is 0 and its hiz flag is 0.
- R2: When a phase's bottom command is 1 and its top command is 0, and nothing is disabling the outputs, that phase's bottom gate is 1, its top gate is 0 and its hiz flag is 0.
- R3: When both commands of a phase are 1, both gates of that phase are 0 and its hiz flag is 1.
- R4: When both commands of a phase are 0, both gates of that phase are 0 and its hiz flag is 1.
- R5: After one gate of a phase falls, the opposite gate of that phase stays 0 for at least DEAD_CYC cycles. When a phase's commands swap in a single cycle, the new gate rises exactly DEAD_CYC cycles after the old gate falls (default DEAD_CYC = 8).
- R6: A 1 on either disable input forces all six gates to 0 and all three hiz flags to 1, whatever the commands are.
- R7: A 1 on either undervoltage flag (phase A domain, or phase B/C domain) forces all six gates to 0 and all three hiz flags to 1. No output reports which source caused this.
- R8: A 1 on the current-limit trip input forces all six gates to 0 and all three hiz flags to 1.
- R9: Every input is synchronized by two flops, and the outputs are registered. An input change shows at the outputs on the third rising clock edge after it, unless a dead-time wait is pending.
- R10: While rst_n is 0, all gates are 0 and all hiz flags are 1.
- R11: The top and bottom gates of one phase are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_top_i | input | 3 | Top commands, bit 0 = phase A, bit 1 = B, bit 2 = C |
| cmd_bot_i | input | 3 | Bottom commands, same bit order |
| dis_a_i | input | 1 | First disable input, 1 = all phases off |
| dis_b_i | input | 1 | Second disable input, 1 = all phases off |
| uv_dom_a_i | input | 1 | Undervoltage on the phase A supply domain |
| uv_dom_bc_i | input | 1 | Undervoltage on the phase B/C supply domain |
| ilim_trip_i | input | 1 | Current-limit trip active |
| gate_top_o | output | 3 | High-side gate enables |
| gate_bot_o | output | 3 | Low-side gate enables |
| hiz_o | output | 3 | Phase floating (neither gate on) |

## Verification
The sharpest corner case is a command swap within one cycle. If the dead-time counter is off by one or missing, the new gate rises early, and the bench sees it at a cycle where a 0 was expected. If the counter never saturates, the gate never rises. Both commands high on one phase is checked directly: a design that gives one device priority would show a driven gate there. Each of the five global kill sources is driven on its own while a phase is commanded on. An OR term left out would leave that gate on. Release of a kill and the three-edge input latency are both sampled on exact cycles.

// File: rtl/tpg_pkg.sv
// Package: shared constants and the per-phase drive decision type.
// Assumes: three phases, bit 0 = A, 1 = B, 2 = C.
package tpg_pkg;

    localparam int NPH = 3;

    typedef enum logic [1:0] {
        DRV_FLOAT = 2'b00,
        DRV_HIGH  = 2'b01,
        DRV_LOW   = 2'b10
    } drive_e;

    // Decode one phase's command pair; conflicting or idle commands float.
    function automatic drive_e decode_drive(input logic top, input logic bot, input logic kill);
        if (kill)             return DRV_FLOAT;
        else if (top && !bot) return DRV_HIGH;
        else if (bot && !top) return DRV_LOW;
        else                  return DRV_FLOAT;
    endfunction

endpackage

// File: rtl/tpg_sync.sv
// Module: multi-bit flop-chain synchronizer.
// Assumes: each bit is independent (no bus coherency needed); reset clears to 0.
module tpg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the chain each cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[s] <= '0;
                else if (s == 0) chain[s] <= d_i;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tpg_kill.sv
// Module: merges all global shutdown sources into one kill level.
// Assumes: every source is already synchronized and active high.
module tpg_kill #(
    parameter int NSRC = 5
) (
    input  logic [NSRC-1:0] src_i,
    output logic            kill_o
);
    // Any active source shuts every phase down.
    always_comb kill_o = |src_i;
endmodule

// File: rtl/tpg_phase.sv
// Module: gate decision and dead-time guard for one half bridge.
// Assumes: inputs synchronized; DEAD_CYC >= 1. Gates and hiz are registered.
module tpg_phase
    import tpg_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_top,
    input  logic cmd_bot,
    input  logic kill,
    output logic gate_top,
    output logic gate_bot,
    output logic hiz
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEAD_CYC);
    localparam logic [CW-1:0] CNT_GO  = CW'(DEAD_CYC - 1);

    drive_e       want;
    logic [CW-1:0] top_off_cnt, bot_off_cnt;
    logic          top_d, bot_d;

    // Requested drive for this cycle.
    always_comb want = decode_drive(cmd_top, cmd_bot, kill);

    // A gate may rise only when the opposite gate has been off long enough.
    always_comb begin
        top_d = (want == DRV_HIGH) && !gate_bot && (bot_off_cnt >= CNT_GO);
        bot_d = (want == DRV_LOW)  && !gate_top && (top_off_cnt >= CNT_GO);
    end

    // Count cycles since each gate was last on, saturating at the dead time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_off_cnt <= CNT_MAX;
            bot_off_cnt <= CNT_MAX;
        end else begin
            if (gate_top)                  top_off_cnt <= '0;
            else if (top_off_cnt < CNT_MAX) top_off_cnt <= top_off_cnt + 1'b1;
            if (gate_bot)                  bot_off_cnt <= '0;
            else if (bot_off_cnt < CNT_MAX) bot_off_cnt <= bot_off_cnt + 1'b1;
        end
    end

    // Register the gate enables and the floating flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_top <= 1'b0;
            gate_bot <= 1'b0;
            hiz      <= 1'b1;
        end else begin
            gate_top <= top_d;
            gate_bot <= bot_d;
            hiz      <= !(top_d || bot_d);
        end
    end
endmodule

// File: rtl/tri_phase_gate_ctrl.sv
// Module: three-phase protected gate control (top).
// Assumes: asynchronous inputs, all synchronized here; one clock domain.
module tri_phase_gate_ctrl
    import tpg_pkg::*;
#(
    parameter int DEAD_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] cmd_top_i,
    input  logic [NPH-1:0] cmd_bot_i,
    input  logic           dis_a_i,
    input  logic           dis_b_i,
    input  logic           uv_dom_a_i,
    input  logic           uv_dom_bc_i,
    input  logic           ilim_trip_i,
    output logic [NPH-1:0] gate_top_o,
    output logic [NPH-1:0] gate_bot_o,
    output logic [NPH-1:0] hiz_o
);
    localparam int NSRC = 5;
    localparam int SW   = 2 * NPH + NSRC;

    logic [SW-1:0]   raw, syn;
    logic [NPH-1:0]  top_s, bot_s;
    logic [NSRC-1:0] src_s;
    logic            kill;

    // Gather every asynchronous input into one bus for synchronizing.
    always_comb raw = {ilim_trip_i, uv_dom_bc_i, uv_dom_a_i, dis_b_i, dis_a_i, cmd_bot_i, cmd_top_i};

    tpg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
    );

    // Split the synchronized bus back into commands and shutdown sources.
    always_comb begin
        top_s = syn[NPH-1:0];
        bot_s = syn[2*NPH-1:NPH];
        src_s = syn[SW-1:2*NPH];
    end

    tpg_kill #(.NSRC(NSRC)) u_kill (.src_i(src_s), .kill_o(kill));

    generate
        for (genvar p = 0; p < NPH; p++) begin : g_phase
            tpg_phase #(.DEAD_CYC(DEAD_CYC)) u_phase (
                .clk(clk), .rst_n(rst_n),
                .cmd_top(top_s[p]), .cmd_bot(bot_s[p]), .kill(kill),
                .gate_top(gate_top_o[p]), .gate_bot(gate_bot_o[p]), .hiz(hiz_o[p])
            );
        end
    endgenerate
endmodule

// File: rtl/tpg_checker.sv
// Module: port-level protocol checks for tri_phase_gate_ctrl, bound below.
// Assumes: two synchronizer stages plus one output register (3-edge latency).
module tpg_checker #(
    parameter int DEAD_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cmd_top_i,
    input logic [2:0] cmd_bot_i,
    input logic       dis_a_i,
    input logic       dis_b_i,
    input logic       uv_dom_a_i,
    input logic       uv_dom_bc_i,
    input logic       ilim_trip_i,
    input logic [2:0] gate_top_o,
    input logic [2:0] gate_bot_o,
    input logic [2:0] hiz_o
);
    localparam int CW = $clog2(DEAD_CYC + 2);

    // R11: never both devices of a phase on.
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_top_o & gate_bot_o) == 3'b000);

    // R3: conflicting commands leave that phase with no gate on.
    p_conflict_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_top_i & cmd_bot_i, 3) & (gate_top_o | gate_bot_o)) == 3'b000);

    // R6: disable inputs stop every gate.
    p_disable_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis_a_i | dis_b_i, 3) |-> (gate_top_o | gate_bot_o) == 3'b000);

    // R7: undervoltage in either domain stops every gate.
    p_uvlo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uv_dom_a_i | uv_dom_bc_i, 3) |-> (gate_top_o | gate_bot_o) == 3'b000);

    // R8: a current-limit trip stops every gate.
    p_ilim_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ilim_trip_i, 3) |-> (gate_top_o | gate_bot_o) == 3'b000);

    // R10: a reset cycle leaves every gate off and every phase floating.
    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> (gate_top_o == 3'b000) && (gate_bot_o == 3'b000) && (hiz_o == 3'b111));

    generate
        for (genvar p = 0; p < 3; p++) begin : g_dead
            logic [CW-1:0] since_top, since_bot;
            // Track cycles since each gate of this phase was last seen on.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    since_top <= CW'(DEAD_CYC);
                    since_bot <= CW'(DEAD_CYC);
                end else begin
                    if (gate_top_o[p])                 since_top <= '0;
                    else if (since_top < CW'(DEAD_CYC)) since_top <= since_top + 1'b1;
                    if (gate_bot_o[p])                 since_bot <= '0;
                    else if (since_bot < CW'(DEAD_CYC)) since_bot <= since_bot + 1'b1;
                end
            end
            // R5: a rising gate needs the opposite gate off for DEAD_CYC cycles.
            p_dead_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(gate_top_o[p]) |-> since_bot >= CW'(DEAD_CYC));
            p_dead_bot_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(gate_bot_o[p]) |-> since_top >= CW'(DEAD_CYC));
        end
    endgenerate
endmodule

bind tri_phase_gate_ctrl tpg_checker #(.DEAD_CYC(DEAD_CYC)) u_tpg_checker (
    .clk(clk), .rst_n(rst_n), .cmd_top_i(cmd_top_i), .cmd_bot_i(cmd_bot_i),
    .dis_a_i(dis_a_i), .dis_b_i(dis_b_i), .uv_dom_a_i(uv_dom_a_i),
    .uv_dom_bc_i(uv_dom_bc_i), .ilim_trip_i(ilim_trip_i),
    .gate_top_o(gate_top_o), .gate_bot_o(gate_bot_o), .hiz_o(hiz_o)
);

// File: tb/tri_phase_gate_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module tri_phase_gate_ctrl_bench;
    localparam int DEAD = 8;
    localparam int LAT  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_top = 3'b000, cmd_bot = 3'b000;
    logic       dis_a = 1'b0, dis_b = 1'b0, uv_a = 1'b0, uv_bc = 1'b0, ilim = 1'b0;
    logic [2:0] gate_top, gate_bot, hiz;
    int         n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    tri_phase_gate_ctrl #(.DEAD_CYC(DEAD)) u_tri_phase_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_top_i(cmd_top), .cmd_bot_i(cmd_bot),
        .dis_a_i(dis_a), .dis_b_i(dis_b), .uv_dom_a_i(uv_a), .uv_dom_bc_i(uv_bc),
        .ilim_trip_i(ilim), .gate_top_o(gate_top), .gate_bot_o(gate_bot), .hiz_o(hiz)
    );

    task automatic check(input string req, input logic [2:0] et, input logic [2:0] eb, input logic [2:0] eh);
        n_chk++;
        if (gate_top !== et || gate_bot !== eb || hiz !== eh) begin
            n_fail++;
            $display("FAIL %s: top=%b bot=%b hiz=%b expected top=%b bot=%b hiz=%b",
                     req, gate_top, gate_bot, hiz, et, eb, eh);
        end
    endtask

    // Drive inputs just after a falling edge.
    task automatic drive(input logic [2:0] t, input logic [2:0] b);
        @(negedge clk);
        cmd_top = t;
        cmd_bot = b;
    endtask

    // Wait n rising edges, then sample mid-cycle.
    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic settle_idle();
        drive(3'b000, 3'b000);
        {dis_a, dis_b, uv_a, uv_bc, ilim} = '0;
        wait_edges(LAT + DEAD + 2);
    endtask

    task automatic t_reset();
        wait_edges(2);
        check("R10 reset", 3'b000, 3'b000, 3'b111);
        @(negedge clk);
        rst_n = 1'b1;
        wait_edges(1);
        check("R10 after release", 3'b000, 3'b000, 3'b111);
    endtask

    task automatic t_single_drive();
        settle_idle();
        drive(3'b101, 3'b010);  // A top, B bottom, C top
        wait_edges(LAT - 1);
        check("R9 not before third edge", 3'b000, 3'b000, 3'b111);
        wait_edges(1);
        check("R1/R2 mixed drive", 3'b101, 3'b010, 3'b000);
        settle_idle();
        drive(3'b010, 3'b101);
        wait_edges(LAT);
        check("R1/R2 swapped pattern", 3'b010, 3'b101, 3'b000);
        check("R9 latency three edges", 3'b010, 3'b101, 3'b000);
    endtask

    task automatic t_conflict_and_idle();
        settle_idle();
        drive(3'b011, 3'b110);  // B conflicts, A top, C bottom
        wait_edges(LAT);
        check("R3 conflict on B", 3'b001, 3'b100, 3'b010);
        settle_idle();
        drive(3'b111, 3'b111);
        wait_edges(LAT);
        check("R3 conflict on all", 3'b000, 3'b000, 3'b111);
        drive(3'b000, 3'b000);
        wait_edges(LAT);
        check("R4 idle commands", 3'b000, 3'b000, 3'b111);
    endtask

    task automatic t_dead_swap();
        settle_idle();
        drive(3'b000, 3'b001);          // A bottom on
        wait_edges(LAT + 1);
        check("R2 phase A bottom", 3'b000, 3'b001, 3'b110);
        drive(3'b001, 3'b000);          // swap in one cycle
        wait_edges(LAT);
        check("R5 bottom off, top held", 3'b000, 3'b000, 3'b111);
        wait_edges(DEAD - 1);
        check("R5 top still off one cycle early", 3'b000, 3'b000, 3'b111);
        wait_edges(1);
        check("R5 top on after dead time", 3'b001, 3'b000, 3'b110);
        drive(3'b000, 3'b001);          // swap back
        wait_edges(LAT + DEAD - 1);
        check("R5 bottom held one cycle early", 3'b000, 3'b000, 3'b111);
        wait_edges(1);
        check("R5 bottom on after dead time", 3'b000, 3'b001, 3'b110);
    endtask

    task automatic t_kill(input int which, input string req);
        settle_idle();
        drive(3'b101, 3'b010);
        wait_edges(LAT);
        @(negedge clk);
        case (which)
            0: dis_a = 1'b1;
            1: dis_b = 1'b1;
            2: uv_a  = 1'b1;
            3: uv_bc = 1'b1;
            default: ilim = 1'b1;
        endcase
        wait_edges(LAT);
        check(req, 3'b000, 3'b000, 3'b111);
        @(negedge clk);
        {dis_a, dis_b, uv_a, uv_bc, ilim} = '0;
        wait_edges(LAT);
        check({req, " released"}, 3'b101, 3'b010, 3'b000);
    endtask

    initial begin
        t_reset();
        t_single_drive();
        t_conflict_and_idle();
        t_dead_swap();
        t_kill(0, "R6 first disable");
        t_kill(1, "R6 second disable");
        t_kill(2, "R7 undervoltage A");
        t_kill(3, "R7 undervoltage BC");
        t_kill(4, "R8 current limit");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule